// File: doc/BRIEF.md
# ATM Receive Cell Word Packer

This block sits behind the receive side of an ATM physical interface. It takes one octet per cycle, marked valid, along with a start-of-cell flag and an error flag. It tracks where each byte falls inside a 53-byte cell. It drops the header check byte, which is the fifth header byte, and packs the other 52 bytes big-endian into thirteen 32-bit words. Those words go to a receive FIFO as one uninterrupted burst.

The bytes of a cell are first staged inside the block. A cell is released to the FIFO only after all 52 of its data bytes have arrived intact. There are two staging banks, so one cell can drain while the next one fills. When the FIFO cannot take a whole cell, the cell is dropped and a sticky overflow flag is raised. When framing is lost, the partial cell is thrown away, a sticky sync flag is raised, and the block hunts for the next start-of-cell marker.

Back-pressure works as follows. The byte input cannot be stalled, because a physical line cannot be held. On the word output, `out_valid` and `out_data` stay unchanged until `out_ready` is seen high on a clock edge. `fifo_free` reports how many FIFO entries are empty. It is only consulted at the moment a cell completes.

Top module: `atm_rx_packer`

## Requirements
- R1: After reset `out_valid`, `sync_lost` and `fifo_ovfl` are 0, and the block is hunting: it needs a start-of-cell marker before it accepts any byte.
- R2: While hunting, every byte without a marker is ignored. Such bytes produce no output and raise no flag. A byte carrying both marker and error is also ignored. The first marked, error-free byte becomes cell byte 0.
- R3: The cell byte at index 4 (the header check byte) is discarded. Each intact 53-byte cell yields exactly 13 output words.
- R4: Word 0 is cell bytes 0,1,2,3, and word k (k = 1..12) is cell bytes 4k+1 to 4k+4. In each word the earliest byte sits in bits [31:24] and the latest in bits [7:0].
- R5: The 13 words of a cell leave in order as one burst. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged.
- R6: When the last byte of a cell is accepted, the cell is committed only if `fifo_free` is at least 13. Otherwise none of its words are output and `fifo_ovfl` is set.
- R7: A cell that completes while the previous cell's burst is still unfinished is dropped whole, and `fifo_ovfl` is set. The pending burst is delivered unchanged.
- R8: While locked, the block treats three cases as a framing error: a marker at any position other than 0, no marker at position 0, or `rx_err` on a byte. It then sets `sync_lost`, discards the partial cell and that byte, and returns to hunting.
- R9: `sync_lost` and `fifo_ovfl` stay set until their own clear input is pulsed. Each clear affects only its own flag.
- R10: Cells arriving back to back, with no idle cycle between them, are each delivered complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte present on `rx_byte` this cycle |
| rx_byte | input | 8 | Received octet |
| rx_soc | input | 1 | Byte is the first of a cell |
| rx_err | input | 1 | Physical layer marks this byte as bad |
| fifo_free | input | FREE_W | Empty entries in the receive FIFO |
| out_valid | output | 1 | Word available on `out_data` |
| out_data | output | 32 | Packed word, earliest byte in [31:24] |
| out_ready | input | 1 | FIFO accepts the word this cycle |
| clr_sync | input | 1 | Pulse to clear `sync_lost` |
| clr_ovfl | input | 1 | Pulse to clear `fifo_ovfl` |
| sync_lost | output | 1 | Sticky framing-loss flag |
| fifo_ovfl | output | 1 | Sticky overflow flag |

## Verification
The bench probes the room boundary at exactly 13 and 12 free entries. A wrong comparison there would either leak a cell into a FIFO that cannot hold it or refuse a cell that fits. Framing errors are injected mid-cell, at position 0 and through the error flag, and the next good cell is checked word for word. A design that kept the stale partial words or that miscounted on resync would emit shifted or mixed data. Holding `out_ready` low across a second complete cell checks two things. A design without the busy check would overwrite the pending bank, and one without the stall hold would lose or repeat words. Byte values that wrap past 0xFF, and two cells sent back to back, expose errors in lane order and bank switching.

// File: rtl/atm_rx_pkg.sv
package atm_rx_pkg;
  localparam int CELL_BYTES = 53;
  localparam int HEC_INDEX  = 4;
  localparam int BYTE_BITS  = 8;
  localparam int WORD_BYTES = 4;
  localparam int CELL_WORDS = (CELL_BYTES - 1) / WORD_BYTES;

  typedef enum logic {
    TRK_HUNT = 1'b0,
    TRK_LOCK = 1'b1
  } trk_state_e;
endpackage

// File: rtl/cell_tracker.sv
module cell_tracker
  import atm_rx_pkg::*;
#(
  parameter int NBYTES  = CELL_BYTES,
  parameter int HEC_POS = HEC_INDEX
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_vld,
  input  logic byte_soc,
  input  logic byte_err,
  output logic keep,
  output logic restart,
  output logic sync_err
);
  localparam int POS_W = $clog2(NBYTES);
  localparam logic [POS_W-1:0] HEC_P  = POS_W'(HEC_POS);
  localparam logic [POS_W-1:0] LAST_P = POS_W'(NBYTES - 1);

  trk_state_e       state_q;
  logic [POS_W-1:0] pos_q;
  logic             at_start;
  logic             framing_bad;

  assign at_start    = (pos_q == '0);
  assign framing_bad = byte_err || (byte_soc != at_start);

  always_comb begin
    keep     = 1'b0;
    restart  = 1'b0;
    sync_err = 1'b0;
    if (byte_vld) begin
      if (state_q == TRK_HUNT) begin
        if (byte_soc && !byte_err) begin
          keep    = 1'b1;
          restart = 1'b1;
        end
      end else if (framing_bad) begin
        sync_err = 1'b1;
        restart  = 1'b1;
      end else begin
        keep    = (pos_q != HEC_P);
        restart = at_start;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TRK_HUNT;
      pos_q   <= '0;
    end else if (byte_vld) begin
      if (state_q == TRK_HUNT) begin
        if (byte_soc && !byte_err) begin
          state_q <= TRK_LOCK;
          pos_q   <= POS_W'(1);
        end
      end else if (framing_bad) begin
        state_q <= TRK_HUNT;
        pos_q   <= '0;
      end else begin
        pos_q <= (pos_q == LAST_P) ? '0 : pos_q + POS_W'(1);
      end
    end
  end
endmodule

// File: rtl/word_assembler.sv
module word_assembler
  import atm_rx_pkg::*;
#(
  parameter int BW     = BYTE_BITS,
  parameter int NLANES = WORD_BYTES,
  parameter int NWORDS = CELL_WORDS,
  localparam int WW     = BW * NLANES,
  localparam int WIDX_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keep,
  input  logic              restart,
  input  logic [BW-1:0]     byte_in,
  output logic              wr_en,
  output logic [WIDX_W-1:0] wr_idx,
  output logic [WW-1:0]     wr_word,
  output logic              cell_done
);
  localparam int LANE_W = $clog2(NLANES);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NLANES - 1);
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(NWORDS - 1);

  logic [LANE_W-1:0]  lane_q, cur_lane;
  logic [WIDX_W-1:0]  widx_q, cur_widx;
  logic [WW-BW-1:0]   acc_q;

  assign cur_lane  = restart ? '0 : lane_q;
  assign cur_widx  = restart ? '0 : widx_q;
  assign wr_en     = keep && (cur_lane == LAST_LANE);
  assign wr_idx    = cur_widx;
  assign wr_word   = {acc_q, byte_in};
  assign cell_done = wr_en && (cur_widx == LAST_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_q <= '0;
      widx_q <= '0;
      acc_q  <= '0;
    end else if (keep) begin
      acc_q <= {acc_q[WW-2*BW-1:0], byte_in};
      if (cur_lane == LAST_LANE) begin
        lane_q <= '0;
        widx_q <= (cur_widx == LAST_WORD) ? '0 : cur_widx + WIDX_W'(1);
      end else begin
        lane_q <= cur_lane + LANE_W'(1);
        widx_q <= cur_widx;
      end
    end else if (restart) begin
      lane_q <= '0;
      widx_q <= '0;
    end
  end
endmodule

// File: rtl/cell_stager.sv
module cell_stager
  import atm_rx_pkg::*;
#(
  parameter int WW     = BYTE_BITS * WORD_BYTES,
  parameter int NWORDS = CELL_WORDS,
  parameter int FREE_W = 8,
  localparam int WIDX_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_idx,
  input  logic [WW-1:0]     wr_word,
  input  logic              cell_done,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WW-1:0]     out_data,
  output logic              drop
);
  localparam int NBANKS = 2;
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(NWORDS - 1);
  localparam logic [FREE_W-1:0] NEED     = FREE_W'(NWORDS);

  logic              fill_sel_q, drain_sel_q, busy_q;
  logic [WIDX_W-1:0] didx_q;
  logic [WW-1:0]     bank_rd [NBANKS];
  logic              room, accept;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [WW-1:0] mem [NWORDS];
    always_ff @(posedge clk) begin
      if (wr_en && (fill_sel_q == 1'(b))) mem[wr_idx] <= wr_word;
    end
    assign bank_rd[b] = mem[didx_q];
  end

  assign room      = (fifo_free >= NEED);
  assign accept    = cell_done && !busy_q && room;
  assign drop      = cell_done && !accept;
  assign out_valid = busy_q;
  assign out_data  = bank_rd[drain_sel_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_sel_q  <= 1'b0;
      drain_sel_q <= 1'b0;
      busy_q      <= 1'b0;
      didx_q      <= '0;
    end else if (accept) begin
      fill_sel_q  <= ~fill_sel_q;
      drain_sel_q <= fill_sel_q;
      busy_q      <= 1'b1;
      didx_q      <= '0;
    end else if (busy_q && out_ready) begin
      if (didx_q == LAST_WORD) begin
        busy_q <= 1'b0;
        didx_q <= '0;
      end else begin
        didx_q <= didx_q + WIDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/atm_rx_packer.sv
module atm_rx_packer
  import atm_rx_pkg::*;
#(
  parameter int FREE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_soc,
  input  logic              rx_err,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              out_valid,
  output logic [31:0]       out_data,
  input  logic              out_ready,
  input  logic              clr_sync,
  input  logic              clr_ovfl,
  output logic              sync_lost,
  output logic              fifo_ovfl
);
  localparam int WW     = BYTE_BITS * WORD_BYTES;
  localparam int WIDX_W = $clog2(CELL_WORDS);

  logic              keep, restart, sync_err;
  logic              wr_en, cell_done, drop;
  logic [WIDX_W-1:0] wr_idx;
  logic [WW-1:0]     wr_word;

  cell_tracker #(.NBYTES(CELL_BYTES), .HEC_POS(HEC_INDEX)) u_trk (
    .clk(clk), .rst_n(rst_n), .byte_vld(rx_valid), .byte_soc(rx_soc),
    .byte_err(rx_err), .keep(keep), .restart(restart), .sync_err(sync_err)
  );

  word_assembler #(.BW(BYTE_BITS), .NLANES(WORD_BYTES), .NWORDS(CELL_WORDS)) u_asm (
    .clk(clk), .rst_n(rst_n), .keep(keep), .restart(restart), .byte_in(rx_byte),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word), .cell_done(cell_done)
  );

  cell_stager #(.WW(WW), .NWORDS(CELL_WORDS), .FREE_W(FREE_W)) u_stg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
    .cell_done(cell_done), .fifo_free(fifo_free), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .drop(drop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_lost <= 1'b0;
      fifo_ovfl <= 1'b0;
    end else begin
      sync_lost <= sync_err | (sync_lost & ~clr_sync);
      fifo_ovfl <= drop | (fifo_ovfl & ~clr_ovfl);
    end
  end
endmodule

// File: rtl/atm_rx_packer_chk.sv
module atm_rx_packer_chk #(
  parameter int NWORDS = 13
) (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        sync_lost,
  input logic        clr_sync,
  input logic        fifo_ovfl,
  input logic        clr_ovfl
);
  localparam int CW = $clog2(NWORDS + 1);
  logic [CW-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) beat_q <= '0;
    else if (out_valid && out_ready)
      beat_q <= (beat_q == CW'(NWORDS - 1)) ? '0 : beat_q + CW'(1);
  end

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R5
  whole_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> beat_q == '0);

  // R9
  sync_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost && !clr_sync |=> sync_lost);

  // R9
  ovfl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovfl && !clr_ovfl |=> fifo_ovfl);
endmodule

bind atm_rx_packer atm_rx_packer_chk #(.NWORDS(atm_rx_pkg::CELL_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .sync_lost(sync_lost), .clr_sync(clr_sync),
  .fifo_ovfl(fifo_ovfl), .clr_ovfl(clr_ovfl)
);

// File: tb/atm_rx_packer_tb_top.sv
`timescale 1ns/1ps
module atm_rx_packer_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rx_valid = 0, rx_soc = 0, rx_err = 0;
  logic [7:0]  rx_byte = 0;
  logic [7:0]  fifo_free = 8'd200;
  logic        out_valid, out_ready = 1, clr_sync = 0, clr_ovfl = 0;
  logic [31:0] out_data;
  logic        sync_lost, fifo_ovfl;
  int          nchk = 0, nfail = 0, rdy_mode = 0;
  logic [31:0] got[$];
  logic [31:0] expq[$];
  logic        stall_prev = 0;
  logic [31:0] data_prev = 0;

  // fields: [23:16] first byte value, [15:8] fifo_free, [7:4] ready mode, [0] commit expected
  localparam logic [23:0] VEC [5] = '{
    {8'h00, 8'd13,  4'd0, 4'd1},
    {8'h40, 8'd12,  4'd0, 4'd0},
    {8'h80, 8'd200, 4'd1, 4'd1},
    {8'hF0, 8'd255, 4'd1, 4'd1},
    {8'h11, 8'd0,   4'd0, 4'd0}
  };

  always #5 clk = ~clk;

  atm_rx_packer dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_soc(rx_soc), .rx_err(rx_err), .fifo_free(fifo_free),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .clr_sync(clr_sync), .clr_ovfl(clr_ovfl), .sync_lost(sync_lost),
    .fifo_ovfl(fifo_ovfl)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) check(out_valid && out_data == data_prev, "R5 stall hold", out_data, data_prev);
      if (out_valid && out_ready) got.push_back(out_data);
      stall_prev = out_valid && !out_ready;
      data_prev  = out_data;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      case (rdy_mode)
        0: out_ready = 1;
        1: out_ready = ~out_ready;
        default: out_ready = 0;
      endcase
    end
  end

  function automatic logic [7:0] cb(input logic [7:0] base, input int p);
    return base + 8'(p);
  endfunction

  // R4 model: word 0 = bytes 0..3, word k = bytes 4k+1..4k+4
  task automatic push_exp(input logic [7:0] base);
    for (int k = 0; k < 13; k++) begin
      int s = (k == 0) ? 0 : 4 * k + 1;
      expq.push_back({cb(base, s), cb(base, s + 1), cb(base, s + 2), cb(base, s + 3)});
    end
  endtask

  task automatic compare(input string req);
    check(got.size() == expq.size(), req, got.size(), expq.size());
    if (got.size() == expq.size())
      foreach (expq[i]) check(got[i] == expq[i], req, got[i], expq[i]);
    got.delete();
    expq.delete();
  endtask

  task automatic send_byte(input logic [7:0] d, input logic soc, input logic err);
    rx_valid = 1; rx_byte = d; rx_soc = soc; rx_err = err;
    @(posedge clk); #1;
    rx_valid = 0; rx_soc = 0; rx_err = 0;
  endtask

  task automatic send_cell(input logic [7:0] base, input int n);
    for (int p = 0; p < n; p++) send_byte(cb(base, p), p == 0, 1'b0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input bit which_sync);
    if (which_sync) clr_sync = 1; else clr_ovfl = 1;
    @(posedge clk); #1;
    clr_sync = 0; clr_ovfl = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nfail, nchk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    check(!out_valid && !sync_lost && !fifo_ovfl, "R1 reset", {out_valid, sync_lost, fifo_ovfl}, 0);

    // R2 bytes with no marker while hunting, and a marker carrying an error
    for (int i = 0; i < 10; i++) send_byte(8'(i + 3), 0, 0);
    send_byte(8'h77, 1, 1);
    for (int i = 0; i < 52; i++) send_byte(8'(i), 0, 0);
    idle(20);
    check(!sync_lost, "R2 hunt no flag", sync_lost, 0);
    compare("R2 hunt no output");

    // R3 R4 R6 table walk
    for (int r = 0; r < 5; r++) begin
      logic [23:0] v = VEC[r];
      fifo_free = v[15:8];
      rdy_mode  = int'(v[7:4]);
      send_cell(v[23:16], 53);
      if (v[0]) push_exp(v[23:16]);
      idle(40);
      compare("R3 R4 cell words");
      check(fifo_ovfl == !v[0], "R6 room check", fifo_ovfl, !v[0]);
      pulse(0);
      check(!fifo_ovfl, "R9 ovfl clear", fifo_ovfl, 0);
    end
    rdy_mode = 0; fifo_free = 8'd200;

    // R8 marker at wrong position
    send_cell(8'h20, 20);
    send_byte(8'h55, 1, 0);
    check(sync_lost, "R8 misplaced marker", sync_lost, 1);
    send_cell(8'h30, 53);
    push_exp(8'h30);
    idle(30);
    compare("R8 resync after misplaced marker");
    pulse(1);
    check(!sync_lost, "R9 sync clear", sync_lost, 0);

    // R8 missing marker at position 0
    send_cell(8'h60, 53);
    push_exp(8'h60);
    send_byte(8'h99, 0, 0);
    check(sync_lost, "R8 missing marker", sync_lost, 1);
    idle(30);
    compare("R8 cell before missing marker");
    pulse(1);
    for (int i = 0; i < 5; i++) send_byte(8'(i), 0, 0);
    idle(5);
    check(!sync_lost, "R2 hunt after error", sync_lost, 0);
    compare("R2 hunt after error no output");

    // R8 error byte mid-cell
    send_cell(8'h70, 30);
    send_byte(8'hAA, 0, 1);
    idle(20);
    check(sync_lost, "R8 error byte", sync_lost, 1);
    compare("R8 partial cell discarded");

    // R9 independent clears
    fifo_free = 0;
    send_cell(8'h05, 53);
    idle(2);
    fifo_free = 8'd200;
    pulse(1);
    check(!sync_lost && fifo_ovfl, "R9 clear sync only", {sync_lost, fifo_ovfl}, 2'b01);
    pulse(0);
    check(!fifo_ovfl, "R9 clear ovfl", fifo_ovfl, 0);
    compare("R6 dropped cell no output");

    // R10 back to back
    send_cell(8'h21, 53);
    send_cell(8'hA3, 53);
    push_exp(8'h21);
    push_exp(8'hA3);
    idle(30);
    compare("R10 back to back");
    check(!fifo_ovfl, "R10 no overflow", fifo_ovfl, 0);

    // R7 cell completes while burst stalled
    rdy_mode = 2;
    idle(1);
    send_cell(8'h31, 53);
    send_cell(8'h62, 53);
    check(fifo_ovfl, "R7 busy drop flag", fifo_ovfl, 1);
    check(out_valid, "R7 burst held", out_valid, 1);
    push_exp(8'h31);
    rdy_mode = 0;
    idle(30);
    compare("R7 pending burst intact");

    $display("Result: errors=%0d of %0d checks", nfail, nchk);
    $finish;
  end
endmodule